// File: doc/BRIEF.md
# Capture/Compare Channel Array

This block is a set of capture/compare channels that sit beside a free-running real-time counter. Each channel owns a value register and a small configuration word. In capture mode the channel copies the main counter into its value register when the selected edge of a shared event input arrives. In compare mode it checks its value against one of two views of time: the main counter, or a joined word built from the low counter bits and the pre-counter. Any number of the top bits (0 to 31) can be left out of that check. On a match the channel drives its output by a programmed action and sets a sticky flag.

Software-side writes come in through one write port. A channel index selects the target, and a select bit picks the configuration word or the value register. An index at or above the channel count is dropped. The event input passes through a two-flop synchronizer that all channels share. Each channel then picks its own edge rule. Flags are cleared through a per-channel write-one-to-clear input.

Top module: `ccmp_timer`

## Requirements
- R1: After reset every value register reads 0, every output and flag is 0, and every channel is in off mode with pulse action, main-counter base, rising-edge select and a mask of 0.
- R2: A write with `wr_idx` at or above the channel count (index 3 with three channels) changes no value register and no configuration.
- R3: The configuration word is written with `wr_cfg`=1 and has these fields: bits [1:0] mode (0 off, 1 capture, 2 compare), bits [3:2] action (0 pulse, 1 toggle, 2 clear, 3 set), bits [5:4] edge (0 rising, 1 falling, 2 both, 3 level), bit [6] base (0 main, 1 joined) and bits [11:7] mask. In capture mode with rising edge, the value register takes the `cnt` value present in the cycle the synchronized edge is seen, which is the second clock edge after the input changes. The value is taken once per edge.
- R4: With falling select, only high-to-low transitions capture. With both select, either transition captures.
- R5: With level select the input is used as it is: the channel captures `cnt` on every cycle the synchronized input is high.
- R6: In compare mode a match is flagged only in the first cycle that the compared view equals the value. A counter that stays on the value does not match again.
- R7: With base 1 the compared view is `{cnt[16:0], precnt[14:0]}`. With base 0 it is `cnt`.
- R8: A mask of m leaves the m most significant bits out of the comparison.
- R9: With pulse action the output is high for exactly the one cycle after a match.
- R10: A match with toggle action inverts the output, with clear action drives it to 0, and with set action drives it to 1. Without a match the output holds.
- R11: The flag is set one cycle after a capture or a match. It stays set until its `flag_clr` bit is asserted. If a set and a clear come in the same cycle, the set wins.
- R12: A channel in off mode never captures, never matches, and never changes its output or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt | input | 32 | Main counter value |
| precnt | input | 15 | Pre-counter value |
| evt_in | input | 1 | Asynchronous event input shared by all channels |
| wr_en | input | 1 | Write strobe |
| wr_cfg | input | 1 | 1 writes the configuration word, 0 writes the value register |
| wr_idx | input | 2 | Target channel index |
| wr_data | input | 32 | Write data |
| flag_clr | input | 3 | Write-one-to-clear, one bit per channel |
| ccv | output | 96 | Value registers, channel i in bits [32*i+31:32*i] |
| cc_out | output | 3 | Channel outputs |
| flag | output | 3 | Channel event flags |

## Verification
The bench builds the block with its default parameters: three channels, a 32-bit counter and a 15-bit pre-counter. Three channels leave index code 3 of the 2-bit index unused, so the dropped-write rule can be tested at the ports. With the 5-bit mask field, every mask width from 0 to 31 can be reached. The random compare rounds therefore mix both bases, all four actions and arbitrary mask widths, on top of directed edge-select and stalled-counter cases.

// File: rtl/ccmp_pkg.sv
package ccmp_pkg;

    parameter int CNT_W  = 32;
    parameter int PRE_W  = 15;
    parameter int LOW_W  = CNT_W - PRE_W;
    parameter int MASK_W = $clog2(CNT_W);

    typedef enum logic [1:0] {
        CH_OFF     = 2'd0,
        CH_CAPTURE = 2'd1,
        CH_COMPARE = 2'd2,
        CH_SPARE   = 2'd3
    } ch_mode_e;

    typedef enum logic [1:0] {
        ACT_PULSE  = 2'd0,
        ACT_TOGGLE = 2'd1,
        ACT_CLEAR  = 2'd2,
        ACT_SET    = 2'd3
    } ch_act_e;

    typedef enum logic [1:0] {
        EDG_RISE  = 2'd0,
        EDG_FALL  = 2'd1,
        EDG_BOTH  = 2'd2,
        EDG_LEVEL = 2'd3
    } ch_edge_e;

    typedef enum logic {
        BASE_MAIN   = 1'b0,
        BASE_JOINED = 1'b1
    } ch_base_e;

    // Field positions are decoded from the write port: mask at the top, mode at bit 0.
    typedef struct packed {
        logic [MASK_W-1:0] mask;
        ch_base_e          base;
        ch_edge_e          edg;
        ch_act_e           act;
        ch_mode_e          mode;
    } ch_cfg_t;

    localparam int CFG_W = $bits(ch_cfg_t);

    localparam ch_cfg_t CFG_RST = '{
        mask: '0,
        base: BASE_MAIN,
        edg:  EDG_RISE,
        act:  ACT_PULSE,
        mode: CH_OFF
    };

    function automatic logic [CNT_W-1:0] keep_bits(input logic [MASK_W-1:0] m);
        return {CNT_W{1'b1}} >> m;
    endfunction

    function automatic logic edge_hit(input ch_edge_e e, input logic cur, input logic prev);
        logic r;
        unique case (e)
            EDG_RISE:  r = cur & ~prev;
            EDG_FALL:  r = ~cur & prev;
            EDG_BOTH:  r = cur ^ prev;
            default:   r = cur;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ccmp_sync.sv
module ccmp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic level,
    output logic level_prev
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-1:0], d};
    end

    assign level      = sh[STAGES-1];
    assign level_prev = sh[STAGES];
endmodule

// File: rtl/ccmp_match.sv
module ccmp_match
    import ccmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  view_main,
    input  logic [CNT_W-1:0]  view_joined,
    input  ch_base_e          base,
    input  logic [MASK_W-1:0] mask,
    input  logic [CNT_W-1:0]  target,
    output logic              hit
);
    logic [CNT_W-1:0] sel;
    logic             eq;
    logic             eq_q;

    always_comb begin
        sel = (base == BASE_JOINED) ? view_joined : view_main;
        eq  = ((sel ^ target) & keep_bits(mask)) == '0;
    end

    always_ff @(posedge clk) begin
        if (rst) eq_q <= 1'b0;
        else     eq_q <= eq;
    end

    assign hit = eq & ~eq_q;
endmodule

// File: rtl/ccmp_channel.sv
module ccmp_channel
    import ccmp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] joined,
    input  logic             lvl,
    input  logic             lvl_prev,
    input  logic             cfg_we,
    input  logic             val_we,
    input  logic [CNT_W-1:0] wdata,
    input  logic             clr,
    output ch_cfg_t          cfg_o,
    output logic [CNT_W-1:0] val_o,
    output logic             out_o,
    output logic             flag_o
);
    ch_cfg_t          cfg_q;
    logic [CNT_W-1:0] val_q;
    logic             out_q;
    logic             flag_q;
    logic             hit;
    logic             capture;
    logic             match;

    ccmp_match u_match (
        .clk        (clk),
        .rst        (rst),
        .view_main  (cnt),
        .view_joined(joined),
        .base       (cfg_q.base),
        .mask       (cfg_q.mask),
        .target     (val_q),
        .hit        (hit)
    );

    assign capture = (cfg_q.mode == CH_CAPTURE) && edge_hit(cfg_q.edg, lvl, lvl_prev);
    assign match   = (cfg_q.mode == CH_COMPARE) && hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RST;
        end else if (cfg_we) begin
            cfg_q <= ch_cfg_t'(wdata[CFG_W-1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          val_q <= '0;
        else if (val_we)  val_q <= wdata;
        else if (capture) val_q <= cnt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= 1'b0;
        end else if (cfg_q.mode == CH_COMPARE) begin
            unique case (cfg_q.act)
                ACT_PULSE:  out_q <= match;
                ACT_TOGGLE: out_q <= out_q ^ match;
                ACT_CLEAR:  out_q <= out_q & ~match;
                default:    out_q <= out_q | match;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                    flag_q <= 1'b0;
        else if (capture || match)  flag_q <= 1'b1;
        else if (clr)               flag_q <= 1'b0;
    end

    assign cfg_o  = cfg_q;
    assign val_o  = val_q;
    assign out_o  = out_q;
    assign flag_o = flag_q;
endmodule

// File: rtl/ccmp_timer.sv
module ccmp_timer
    import ccmp_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int SYNC_N = 2,
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH + 1) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [CNT_W-1:0]        cnt,
    input  logic [PRE_W-1:0]        precnt,
    input  logic                    evt_in,
    input  logic                    wr_en,
    input  logic                    wr_cfg,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [CNT_W-1:0]        wr_data,
    input  logic [NUM_CH-1:0]       flag_clr,
    output logic [NUM_CH*CNT_W-1:0] ccv,
    output logic [NUM_CH-1:0]       cc_out,
    output logic [NUM_CH-1:0]       flag
);
    logic             lvl;
    logic             lvl_prev;
    logic [CNT_W-1:0] joined;
    logic [NUM_CH-1:0] is_cap;
    logic [NUM_CH-1:0] is_pulse;

    assign joined = {cnt[LOW_W-1:0], precnt};

    ccmp_sync #(.STAGES(SYNC_N)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .d         (evt_in),
        .level     (lvl),
        .level_prev(lvl_prev)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        ch_cfg_t cfg;
        logic    sel;

        assign sel = wr_en && (wr_idx == IDX_W'(i));

        ccmp_channel u_ch (
            .clk     (clk),
            .rst     (rst),
            .cnt     (cnt),
            .joined  (joined),
            .lvl     (lvl),
            .lvl_prev(lvl_prev),
            .cfg_we  (sel & wr_cfg),
            .val_we  (sel & ~wr_cfg),
            .wdata   (wr_data),
            .clr     (flag_clr[i]),
            .cfg_o   (cfg),
            .val_o   (ccv[i*CNT_W +: CNT_W]),
            .out_o   (cc_out[i]),
            .flag_o  (flag[i])
        );

        assign is_cap[i]   = (cfg.mode == CH_CAPTURE);
        assign is_pulse[i] = (cfg.mode == CH_COMPARE) && (cfg.act == ACT_PULSE);
    end
endmodule

// File: rtl/ccmp_timer_chk.sv
module ccmp_timer_chk #(
    parameter int NUM_CH = 3,
    parameter int CNT_W  = 32,
    parameter int IDX_W  = 2
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    wr_en,
    input logic [IDX_W-1:0]        wr_idx,
    input logic [NUM_CH*CNT_W-1:0] ccv,
    input logic [NUM_CH-1:0]       cc_out,
    input logic [NUM_CH-1:0]       flag,
    input logic [NUM_CH-1:0]       flag_clr,
    input logic [NUM_CH-1:0]       is_cap,
    input logic [NUM_CH-1:0]       is_pulse
);
    logic rst_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst_q) begin
            AST_RESET_QUIET: assert (flag == '0 && cc_out == '0 && ccv == '0); // R1
        end
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_a
        AST_BAD_INDEX_IGNORED: assert property (@(posedge clk) disable iff (rst)
            (wr_en && (int'(wr_idx) >= NUM_CH) && !is_cap[i]) |=> $stable(ccv[i*CNT_W +: CNT_W])); // R2

        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
            (flag[i] && !flag_clr[i]) |=> flag[i]); // R11

        AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
            (is_pulse[i] && $past(is_pulse[i]) && cc_out[i]) |=> !cc_out[i]); // R9
    end
endmodule

bind ccmp_timer ccmp_timer_chk #(
    .NUM_CH(NUM_CH),
    .CNT_W (ccmp_pkg::CNT_W),
    .IDX_W (IDX_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .ccv     (ccv),
    .cc_out  (cc_out),
    .flag    (flag),
    .flag_clr(flag_clr),
    .is_cap  (is_cap),
    .is_pulse(is_pulse)
);

// File: tb/ccmp_timer_bench.sv
module ccmp_timer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] cnt = '0;
    logic [14:0] precnt = '0;
    logic        evt_in = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_cfg = 1'b0;
    logic [1:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  flag_clr = '0;
    logic [95:0] ccv;
    logic [2:0]  cc_out;
    logic [2:0]  flag;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ccmp_timer u_ccmp_timer (
        .clk(clk), .rst(rst), .cnt(cnt), .precnt(precnt), .evt_in(evt_in),
        .wr_en(wr_en), .wr_cfg(wr_cfg), .wr_idx(wr_idx), .wr_data(wr_data),
        .flag_clr(flag_clr), .ccv(ccv), .cc_out(cc_out), .flag(flag)
    );

    function automatic logic [31:0] cfgw(input int mode, input int act, input int edg,
                                         input int base, input int mask);
        return {20'd0, 5'(mask), 1'(base), 2'(edg), 2'(act), 2'(mode)};
    endfunction

    function automatic bit same(input logic [31:0] v, input logic [31:0] w, input int mask);
        return ((v ^ w) & (32'hFFFF_FFFF >> mask)) == 32'd0;
    endfunction

    function automatic logic [31:0] chv(input int i);
        return ccv[i*32 +: 32];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input int idx, input bit is_cfg, input logic [31:0] d);
        wr_en = 1'b1; wr_cfg = is_cfg; wr_idx = 2'(idx); wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic put_view(input int base, input logic [31:0] w);
        if (base == 0) begin
            cnt = w; precnt = 15'($urandom);
        end else begin
            cnt = {15'($urandom), w[31:15]}; precnt = w[14:0];
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected below 100000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic exp_out;
        void'($urandom(32'd12345));
        repeat (4) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        for (int i = 0; i < NCH; i++) chk("R1 ccv", chv(i), 32'd0);
        chk("R1 flag", 32'(flag), 32'd0);
        chk("R1 out", 32'(cc_out), 32'd0);

        // R12 off channels ignore events
        evt_in = 1'b1; cnt = 32'h77; repeat (4) tick();
        evt_in = 1'b0; repeat (4) tick();
        chk("R12 flag", 32'(flag), 32'd0);
        chk("R12 ccv0", chv(0), 32'd0);

        // R2 invalid index dropped
        wr(3, 1'b0, 32'hDEAD_BEEF);
        wr(3, 1'b1, cfgw(1, 0, 3, 0, 0));
        evt_in = 1'b1; repeat (4) tick(); evt_in = 1'b0; repeat (4) tick();
        for (int i = 0; i < NCH; i++) chk("R2 ccv", chv(i), 32'd0);
        chk("R2 flag", 32'(flag), 32'd0);

        // R3 R4 edge selects
        wr(0, 1'b1, cfgw(1, 0, 0, 0, 0));
        wr(1, 1'b1, cfgw(1, 0, 1, 0, 0));
        wr(2, 1'b1, cfgw(1, 0, 2, 0, 0));
        evt_in = 1'b1; cnt = 32'hA; tick();
        cnt = 32'hB; tick();
        cnt = 32'hC; tick();
        chk("R3 rise ch0", chv(0), 32'hC);
        chk("R4 fall ch1 idle", chv(1), 32'd0);
        chk("R4 both ch2", chv(2), 32'hC);
        chk("R11 flags set", 32'(flag), 32'b101);
        cnt = 32'hD; repeat (3) tick();
        chk("R3 single capture", chv(0), 32'hC);
        evt_in = 1'b0; cnt = 32'hE; tick();
        cnt = 32'hF; tick();
        cnt = 32'h10; tick();
        chk("R4 fall ch1", chv(1), 32'h10);
        chk("R4 both ch2 fall", chv(2), 32'h10);
        chk("R3 rise ch0 held", chv(0), 32'hC);

        // R5 level select, R11 set beats clear
        wr(0, 1'b1, cfgw(1, 0, 3, 0, 0));
        flag_clr = 3'b111; tick(); flag_clr = '0;
        evt_in = 1'b1; repeat (3) tick();
        cnt = 32'h111; tick();
        chk("R5 level 1", chv(0), 32'h111);
        cnt = 32'h222; tick();
        chk("R5 level 2", chv(0), 32'h222);
        flag_clr = 3'b001; tick(); flag_clr = '0;
        chk("R11 set wins", 32'(flag[0]), 32'd1);
        evt_in = 1'b0; repeat (4) tick();
        flag_clr = 3'b001; tick(); flag_clr = '0;
        chk("R11 clear", 32'(flag[0]), 32'd0);
        cnt = 32'h333; tick();
        chk("R5 stops", chv(0), 32'h222);

        // R6 R9 compare main, pulse
        wr(1, 1'b1, cfgw(0, 0, 0, 0, 0));
        wr(2, 1'b1, cfgw(0, 0, 0, 0, 0));
        cnt = 32'h1233;
        wr(0, 1'b1, cfgw(2, 0, 0, 0, 0));
        wr(0, 1'b0, 32'h1234);
        tick();
        cnt = 32'h1234; tick();
        chk("R9 pulse high", 32'(cc_out[0]), 32'd1);
        chk("R6 match flag", 32'(flag[0]), 32'd1);
        tick();
        chk("R9 pulse low", 32'(cc_out[0]), 32'd0);
        flag_clr = 3'b001; tick(); flag_clr = '0;
        repeat (3) tick();
        chk("R6 stalled no retrigger", 32'(flag[0]), 32'd0);

        // R8 R10 mask with set action
        cnt = 32'h00AB_CDEE;
        wr(0, 1'b1, cfgw(2, 3, 0, 0, 8));
        wr(0, 1'b0, 32'h00AB_CDEF);
        tick();
        cnt = 32'h55AB_CDEF; tick();
        chk("R8 masked match", 32'(flag[0]), 32'd1);
        chk("R10 set", 32'(cc_out[0]), 32'd1);

        // R7 R10 joined base with clear action
        flag_clr = 3'b001; cnt = 32'hFFFE_ABCD; precnt = 15'h1235;
        wr(0, 1'b1, cfgw(2, 2, 0, 1, 0));
        flag_clr = '0;
        wr(0, 1'b0, {cnt[16:0], 15'h1234});
        tick();
        precnt = 15'h1234; tick();
        chk("R7 joined match", 32'(flag[0]), 32'd1);
        chk("R10 clear", 32'(cc_out[0]), 32'd0);

        // Random compare rounds on channel 1
        exp_out = cc_out[1];
        for (int it = 0; it < 48; it++) begin
            int act_r = it % 4;
            int base_r = int'($urandom_range(0, 1));
            int mask_r = int'($urandom_range(0, 31));
            logic [31:0] v = $urandom;
            logic [31:0] w;
            bit m;
            if ($urandom_range(0, 1) == 1) w = (v & (32'hFFFF_FFFF >> mask_r)) |
                                               ($urandom & ~(32'hFFFF_FFFF >> mask_r));
            else w = $urandom;
            m = same(v, w, mask_r);
            wr(1, 1'b1, cfgw(0, 0, 0, 0, 0));
            flag_clr = 3'b010;
            wr(1, 1'b0, v);
            flag_clr = '0;
            put_view(base_r, w ^ 32'd1);
            wr(1, 1'b1, cfgw(2, act_r, 0, base_r, mask_r));
            tick();
            put_view(base_r, w); tick();
            case (act_r)
                0: exp_out = m;
                1: exp_out = exp_out ^ m;
                2: exp_out = exp_out & ~m;
                default: exp_out = exp_out | m;
            endcase
            chk(base_r ? "R7 R8 R6 rand flag joined" : "R8 R6 rand flag main", 32'(flag[1]), 32'(m));
            chk("R10 R9 rand out", 32'(cc_out[1]), 32'(exp_out));
            tick();
            if (act_r == 0) exp_out = 1'b0;
            chk("R9 R10 rand out after", 32'(cc_out[1]), 32'(exp_out));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule